// File: doc/BRIEF.md
# Hardware Cursor Placement and Fetch Control

This block turns a programmed cursor description into the control values that a cursor overlay needs. It takes the cursor's screen position, its hotspot, the start and width of the viewport and the cursor width. From these it computes a signed horizontal offset of the cursor's left edge relative to the viewport. It clamps that offset at zero to give a destination offset, and it decides whether any part of the cursor falls inside the viewport.

From the cursor width, a monochrome flag and the surface pitch, it also derives two fetch codes. One sets how many cursor lines go into each memory request. The other encodes the pitch. An unsupported pitch raises a sticky error flag.

All inputs are captured on a one-cycle load strobe and every output is registered. The downstream clock-ratio scaler is not part of this block. It receives a one-cycle `div_go` pulse that marks a fresh destination offset.

Top module: `cursor_place_ctrl`

## Requirements
- R1: One cycle after a load, `src_off` equals `pos_x - hot_x - vp_start`, treating all three as 16-bit signed values, as an 18-bit two's-complement result.
- R2: `dst_off` equals `src_off` when `src_off` is zero or positive, and is 0 when `src_off` is negative.
- R3: `cur_en` is 0 when `src_off` is greater than or equal to `vp_width`, where `vp_width` is 16-bit unsigned.
- R4: `cur_en` is 0 when `src_off + cur_width` is negative. A sum of exactly 0 leaves the cursor visible.
- R5: `cur_en` is 0 when `surf_addr` is all zero or when `req_en` is 0. Otherwise, when neither edge rule applies, it is 1.
- R6: `lpc_code` is 4 when `mono` is 1 or `cur_width` ≤ 32, 3 when `cur_width` ≤ 64, 2 when `cur_width` ≤ 128, and 1 otherwise.
- R7: `pitch_code` is 0 for a pitch of 64, 1 for 128 and 2 for 256. Any other pitch gives code 0 and sets `pitch_err`.
- R8: `pitch_err` stays set until `err_clr` is high at a clock edge. If a load with a bad pitch happens in the same cycle as a clear, the flag is set.
- R9: Outputs change only in the cycle after a load and hold otherwise. `div_go` is high for exactly the one cycle after each load.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture strobe for all programming inputs |
| err_clr | input | 1 | Clears the sticky pitch error |
| pos_x | input | 16 | Cursor x position, signed |
| hot_x | input | 16 | Hotspot x, signed |
| vp_start | input | 16 | Viewport x start, signed |
| vp_width | input | 16 | Viewport width, unsigned |
| cur_width | input | 9 | Cursor width, 1..256 |
| mono | input | 1 | Monochrome cursor mode |
| pitch | input | 9 | Surface pitch in pixels |
| surf_addr | input | 32 | Cursor surface address |
| req_en | input | 1 | Requested cursor enable |
| src_off | output | 18 | Signed source offset |
| dst_off | output | 18 | Clamped destination offset |
| cur_en | output | 1 | Cursor visible and enabled |
| lpc_code | output | 3 | Lines-per-chunk code |
| pitch_code | output | 2 | Pitch code |
| pitch_err | output | 1 | Sticky unsupported-pitch flag |
| div_go | output | 1 | One-cycle pulse: new destination offset for the scaler |

## Verification
The bench targets the exact edge cases of the visibility rules:
- A left-edge sum of exactly 0 must stay visible. A strict/non-strict mix-up would hide it, or would show the case one pixel further out.
- An offset equal to the viewport width must be hidden. An off-by-one design would show it.

It drives extreme 16-bit operands so that the offset needs more than 16 bits. A design that wraps the subtraction would report a wrong sign, a wrong clamp and a wrong enable.

The width thresholds 32/33, 64, 128/129 and 256 with `mono` check chunk selection, since a comparison that is off by one picks the neighbouring code.

Pitch errors are checked for stickiness across a later valid load, for clearing, and for the case where a set and a clear arrive together. A design that lets the clear win would drop a real error.

// File: rtl/cursor_place_ctrl.sv
module cursor_place_ctrl #(
  parameter int PW  = 16,
  parameter int WW  = 9,
  parameter int AW  = 32,
  parameter int PIW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          err_clr,
  input  logic [PW-1:0] pos_x,
  input  logic [PW-1:0] hot_x,
  input  logic [PW-1:0] vp_start,
  input  logic [PW-1:0] vp_width,
  input  logic [WW-1:0] cur_width,
  input  logic          mono,
  input  logic [PIW-1:0] pitch,
  input  logic [AW-1:0] surf_addr,
  input  logic          req_en,
  output logic [PW+1:0] src_off,
  output logic [PW+1:0] dst_off,
  output logic          cur_en,
  output logic [2:0]    lpc_code,
  output logic [1:0]    pitch_code,
  output logic          pitch_err,
  output logic          div_go
);
  localparam int OW = PW + 2;

  logic signed [OW-1:0] src_n, vpw_x, wid_x, sum_n;
  logic                 past_right, past_left, en_n, bad_pitch;
  logic [2:0]           lpc_n;
  logic [1:0]           pc_n;

  assign src_n = OW'($signed(pos_x)) - OW'($signed(hot_x)) - OW'($signed(vp_start));
  assign vpw_x = $signed({2'b00, vp_width});
  assign wid_x = $signed({{(OW-WW){1'b0}}, cur_width});
  assign sum_n = src_n + wid_x;

  assign past_right = src_n >= vpw_x;
  assign past_left  = sum_n[OW-1];
  assign en_n = req_en && (surf_addr != '0) && !past_right && !past_left;

  always_comb begin
    if (mono || cur_width <= WW'(32)) lpc_n = 3'd4;
    else if (cur_width <= WW'(64))    lpc_n = 3'd3;
    else if (cur_width <= WW'(128))   lpc_n = 3'd2;
    else                              lpc_n = 3'd1;
  end

  always_comb begin
    bad_pitch = 1'b0;
    case (pitch)
      PIW'(64):  pc_n = 2'd0;
      PIW'(128): pc_n = 2'd1;
      PIW'(256): pc_n = 2'd2;
      default: begin
        pc_n = 2'd0;
        bad_pitch = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_off    <= '0;
      dst_off    <= '0;
      cur_en     <= 1'b0;
      lpc_code   <= 3'd0;
      pitch_code <= 2'd0;
      pitch_err  <= 1'b0;
      div_go     <= 1'b0;
    end else begin
      div_go    <= load;
      pitch_err <= (pitch_err && !err_clr) || (load && bad_pitch);
      if (load) begin
        src_off    <= src_n;
        dst_off    <= src_n[OW-1] ? '0 : src_n;
        cur_en     <= en_n;
        lpc_code   <= lpc_n;
        pitch_code <= pc_n;
      end
    end
  end
endmodule

// File: rtl/cursor_place_ctrl_chk.sv
module cursor_place_ctrl_chk #(
  parameter int PW  = 16,
  parameter int WW  = 9,
  parameter int AW  = 32,
  parameter int PIW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          err_clr,
  input logic [AW-1:0] surf_addr,
  input logic          req_en,
  input logic [PIW-1:0] pitch,
  input logic [PW+1:0] src_off,
  input logic [PW+1:0] dst_off,
  input logic          cur_en,
  input logic [2:0]    lpc_code,
  input logic [1:0]    pitch_code,
  input logic          pitch_err,
  input logic          div_go
);
  logic odd_pitch;
  assign odd_pitch = (pitch != PIW'(64)) && (pitch != PIW'(128)) && (pitch != PIW'(256));

  p_dst_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_off == (src_off[PW+1] ? '0 : src_off));

  p_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (surf_addr == '0 || !req_en)) |=> !cur_en);

  p_lpc_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> (lpc_code >= 3'd1 && lpc_code <= 3'd4));

  p_bad_pitch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && odd_pitch) |=> (pitch_err && pitch_code == 2'd0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pitch_err && !err_clr) |=> pitch_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(src_off) && $stable(cur_en) && $stable(lpc_code) && $stable(pitch_code) && !div_go));
endmodule

bind cursor_place_ctrl cursor_place_ctrl_chk #(.PW(PW), .WW(WW), .AW(AW), .PIW(PIW)) u_chk (.*);

// File: tb/tb_cursor_place_ctrl.sv
module tb_cursor_place_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, err_clr = 1'b0;
  logic [15:0] pos_x = '0, hot_x = '0, vp_start = '0, vp_width = 16'd1920;
  logic [8:0]  cur_width = 9'd32, pitch = 9'd64;
  logic        mono = 1'b0, req_en = 1'b1;
  logic [31:0] surf_addr = 32'h1000;
  logic [17:0] src_off, dst_off;
  logic        cur_en, pitch_err, div_go;
  logic [2:0]  lpc_code;
  logic [1:0]  pitch_code;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cursor_place_ctrl dut (.*);

  localparam int N = 11;
  localparam int V_POS [N] = '{100, 50, 0, 0, 1920, 1919, 10, 0, 0, -32768, 32767};
  localparam int V_HOT [N] = '{10, 0, 64, 65, 0, 0, 0, 0, 0, 32767, -32768};
  localparam int V_VPS [N] = '{20, 100, 0, 0, 0, 0, 0, 0, 0, 32767, -32768};
  localparam int V_WID [N] = '{32, 64, 64, 64, 128, 128, 129, 256, 33, 256, 200};
  localparam int V_MON [N] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_PIT [N] = '{64, 128, 256, 64, 128, 128, 256, 256, 64, 64, 128};
  localparam int E_EN  [N] = '{1, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0};
  localparam int E_LPC [N] = '{4, 3, 3, 3, 2, 2, 1, 4, 3, 1, 1};
  localparam int E_PC  [N] = '{0, 1, 2, 0, 1, 1, 2, 2, 0, 0, 1};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int p, input int h, input int s, input int w,
                         input int m, input int pt);
    @(negedge clk);
    pos_x = 16'(p); hot_x = 16'(h); vp_start = 16'(s);
    cur_width = 9'(w); mono = m[0]; pitch = 9'(pt);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 src", src_off, 0); chk("R10 en", cur_en, 0);
    chk("R10 lpc", lpc_code, 0); chk("R10 err", pitch_err, 0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      longint es;
      do_load(V_POS[i], V_HOT[i], V_VPS[i], V_WID[i], V_MON[i], V_PIT[i]);
      es = longint'(V_POS[i]) - V_HOT[i] - V_VPS[i];
      chk("R1 src_off", longint'($signed(src_off)), es);
      chk("R2 dst_off", longint'($signed(dst_off)), es < 0 ? 0 : es);
      chk("R3 R4 cur_en", cur_en, E_EN[i]);
      chk("R6 lpc_code", lpc_code, E_LPC[i]);
      chk("R7 pitch_code", pitch_code, E_PC[i]);
      chk("R9 div_go", div_go, 1);
    end

    // R9: hold without load
    do_load(70, 0, 0, 32, 0, 64);
    @(negedge clk);
    chk("R9 div_go low", div_go, 0);
    pos_x = 16'd500; cur_width = 9'd200; pitch = 9'd256;
    repeat (2) @(negedge clk);
    chk("R9 hold src", src_off, 70);
    chk("R9 hold lpc", lpc_code, 4);
    chk("R9 hold pc", pitch_code, 0);

    // R5: zero address and disabled request
    surf_addr = '0;
    do_load(70, 0, 0, 32, 0, 64);
    chk("R5 zero addr", cur_en, 0);
    surf_addr = 32'h1000; req_en = 1'b0;
    do_load(70, 0, 0, 32, 0, 64);
    chk("R5 req off", cur_en, 0);
    req_en = 1'b1;
    do_load(70, 0, 0, 32, 0, 64);
    chk("R5 enabled", cur_en, 1);

    // R7 / R8: pitch error
    do_load(70, 0, 0, 32, 0, 100);
    chk("R7 bad pitch code", pitch_code, 0);
    chk("R7 err set", pitch_err, 1);
    do_load(70, 0, 0, 32, 0, 128);
    chk("R8 sticky", pitch_err, 1);
    chk("R7 good code", pitch_code, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R8 cleared", pitch_err, 0);
    @(negedge clk);
    pitch = 9'd300; load = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    load = 1'b0; err_clr = 1'b0;
    chk("R8 set wins", pitch_err, 1);

    // R10: reset again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset err", pitch_err, 0);
    chk("R10 reset dst", dst_off, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule